// File: doc/BRIEF.md
# Scan Instruction Decoder and Mode Control

This block sits between a test access port controller and the boundary register of a scan-testable device. When the controller strobes an instruction update, the block latches the current instruction word. It then decodes the word into four things: which data register sits between TDI and TDO, how the boundary cells behave on a capture, whether the device pins are under test control or high impedance, and which run-test operation (if any) may proceed.

The block also owns the one-bit bypass register and the final TDO multiplexer, which picks either the boundary chain's serial output or the bypass bit. The controller, the boundary cells and the pattern generation/compression engine are separate blocks. They consume the mode signals produced here.

Opcodes are fixed 8-bit codes. Any code not listed below decodes exactly as the bypass instruction.

Top module: `scan_mode_decoder`

## Requirements
- R1: Opcode 8'hFF (bypass), and every opcode not listed in R3 to R10, gives sel_bsr=0, test_mode=0, out_hiz=0, cap_mode=1 (hold), toggle_en=0 and run_op_en=0.
- R2: The bypass bit loads 0 on a clock edge with capture_dr=1. On an edge with shift_dr=1 (and capture_dr=0) it loads tdi.
- R3: Opcode 8'h00 (external test) gives sel_bsr=1, test_mode=1, out_hiz=0, cap_mode=0 (capture pins and core).
- R4: Opcode 8'h01 (sample/preload) gives sel_bsr=1, test_mode=0, out_hiz=0, cap_mode=0.
- R5: Opcode 8'h02 (float outputs) gives sel_bsr=0, out_hiz=1, test_mode=0, cap_mode=1.
- R6: Opcode 8'h03 (clamp) gives sel_bsr=0, test_mode=1, out_hiz=0, cap_mode=1.
- R7: Opcode 8'h04 (run-test operation) gives sel_bsr=0 and test_mode=1. While rti=1, run_op_en is one-hot, with bit op_sel set (0 sample/toggle, 1 pattern generation, 2 signature compression, 3 both). While rti=0, or under any other instruction, run_op_en=0.
- R8: Opcode 8'h05 (boundary read) gives sel_bsr=1, test_mode=0, cap_mode=1 (hold).
- R9: Opcode 8'h06 (self-test) gives sel_bsr=1, test_mode=0, cap_mode=2 (invert).
- R10: Opcode 8'h07 (output toggle) gives sel_bsr=0, test_mode=1 and cap_mode=3. toggle_en=1 exactly while rti=1 under this instruction.
- R11: After rst_n is asserted, or after a clock edge with tlr=1, the active instruction is bypass (R1 outputs).
- R12: The active instruction changes only on a clock edge with update_ir=1 (and tlr=0). At other times ir_in has no effect on the outputs.
- R13: tdo equals bsr_tdo while sel_bsr=1 and the bypass bit while sel_bsr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tlr | input | 1 | Controller is in Test-Logic-Reset |
| update_ir | input | 1 | Instruction update strobe |
| capture_dr | input | 1 | Data-register capture strobe |
| shift_dr | input | 1 | Data-register shift strobe |
| rti | input | 1 | Controller is in Run-Test/Idle |
| ir_in | input | 8 | Instruction word from the instruction register |
| op_sel | input | 2 | Run-test operation code from the control register |
| tdi | input | 1 | Serial test data in |
| bsr_tdo | input | 1 | Serial output of the boundary chain |
| sel_bsr | output | 1 | 1: boundary register in the scan path; 0: bypass |
| test_mode | output | 1 | Boundary cells drive core inputs and pins |
| out_hiz | output | 1 | All device outputs floated |
| cap_mode | output | 2 | Boundary capture: 0 pins, 1 hold, 2 invert, 3 toggle |
| toggle_en | output | 1 | Output-cell toggling allowed this cycle |
| run_op_en | output | 4 | One-hot enable of the run-test operation |
| tdo | output | 1 | Serial test data out |

## Verification
All mode outputs are combinational functions of one latched opcode. A corrupt active instruction shows at sel_bsr, test_mode, out_hiz and cap_mode in the first cycle after the update edge. The bench compares every one of these outputs on every step, so such a fault cannot hide. A bad bypass bit shows on tdo one edge after the capture or shift that set it. Operation enables that leak out of Run-Test/Idle are visible in the same cycle that rti changes.

// File: rtl/scan_mode_decoder.sv
module scan_mode_decoder #(
  parameter int IR_W = 8
) (
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tlr,
  input  logic            update_ir,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            rti,
  input  logic [IR_W-1:0] ir_in,
  input  logic [1:0]      op_sel,
  input  logic            tdi,
  input  logic            bsr_tdo,
  output logic            sel_bsr,
  output logic            test_mode,
  output logic            out_hiz,
  output logic [1:0]      cap_mode,
  output logic            toggle_en,
  output logic [3:0]      run_op_en,
  output logic            tdo
);
  localparam logic [IR_W-1:0] OP_BYPASS = '1;
  localparam logic [IR_W-1:0] OP_EXTEST = IR_W'(0);
  localparam logic [IR_W-1:0] OP_SAMPLE = IR_W'(1);
  localparam logic [IR_W-1:0] OP_FLOAT  = IR_W'(2);
  localparam logic [IR_W-1:0] OP_CLAMP  = IR_W'(3);
  localparam logic [IR_W-1:0] OP_RUN    = IR_W'(4);
  localparam logic [IR_W-1:0] OP_READ   = IR_W'(5);
  localparam logic [IR_W-1:0] OP_SELF   = IR_W'(6);
  localparam logic [IR_W-1:0] OP_TOGGLE = IR_W'(7);

  localparam logic [1:0] CAP_PINS = 2'd0;
  localparam logic [1:0] CAP_HOLD = 2'd1;
  localparam logic [1:0] CAP_INV  = 2'd2;
  localparam logic [1:0] CAP_TOG  = 2'd3;

  logic [IR_W-1:0] active;
  logic            byp;
  logic            run_sel, tog_sel;

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n)         active <= OP_BYPASS;
    else if (tlr)       active <= OP_BYPASS;
    else if (update_ir) active <= ir_in;

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n)          byp <= 1'b0;
    else if (capture_dr) byp <= 1'b0;
    else if (shift_dr)   byp <= tdi;

  always_comb begin
    sel_bsr   = 1'b0;
    test_mode = 1'b0;
    out_hiz   = 1'b0;
    cap_mode  = CAP_HOLD;
    run_sel   = 1'b0;
    tog_sel   = 1'b0;
    case (active)
      OP_EXTEST: begin sel_bsr = 1'b1; test_mode = 1'b1; cap_mode = CAP_PINS; end
      OP_SAMPLE: begin sel_bsr = 1'b1; cap_mode = CAP_PINS; end
      OP_FLOAT:  out_hiz = 1'b1;
      OP_CLAMP:  test_mode = 1'b1;
      OP_RUN:    begin test_mode = 1'b1; run_sel = 1'b1; end
      OP_READ:   sel_bsr = 1'b1;
      OP_SELF:   begin sel_bsr = 1'b1; cap_mode = CAP_INV; end
      OP_TOGGLE: begin test_mode = 1'b1; cap_mode = CAP_TOG; tog_sel = 1'b1; end
      default:   ;
    endcase
  end

  assign toggle_en = tog_sel & rti;
  assign run_op_en = (run_sel & rti) ? (4'b0001 << op_sel) : 4'b0000;
  assign tdo       = sel_bsr ? bsr_tdo : byp;
endmodule

// File: rtl/scan_mode_decoder_chk.sv
module scan_mode_decoder_chk (
  input logic       tck,
  input logic       rst_n,
  input logic       tlr,
  input logic       update_ir,
  input logic       capture_dr,
  input logic       shift_dr,
  input logic       rti,
  input logic       tdi,
  input logic       sel_bsr,
  input logic       test_mode,
  input logic       out_hiz,
  input logic       toggle_en,
  input logic [3:0] run_op_en,
  input logic       tdo
);
  p_tlr_bypass_r11: assert property (@(posedge tck) disable iff (!rst_n)
    tlr |=> (!sel_bsr && !test_mode && !out_hiz && run_op_en == 4'b0));

  p_capture_zero_r2: assert property (@(posedge tck) disable iff (!rst_n)
    (capture_dr && !sel_bsr && !update_ir && !tlr) |=> (tdo == 1'b0));

  p_shift_in_r2: assert property (@(posedge tck) disable iff (!rst_n)
    (shift_dr && !capture_dr && !sel_bsr && !update_ir && !tlr) |=> (tdo == $past(tdi)));

  p_run_onehot_r7: assert property (@(posedge tck) disable iff (!rst_n)
    (run_op_en != 4'b0) |-> (rti && test_mode && !sel_bsr && $countones(run_op_en) == 1));

  p_hiz_normal_r5: assert property (@(posedge tck) disable iff (!rst_n)
    out_hiz |-> (!test_mode && !sel_bsr));

  p_toggle_rti_r10: assert property (@(posedge tck) disable iff (!rst_n)
    toggle_en |-> (rti && test_mode && !sel_bsr));

  p_hold_r12: assert property (@(posedge tck) disable iff (!rst_n)
    (!update_ir && !tlr) |=> ($stable(sel_bsr) && $stable(test_mode) && $stable(out_hiz)));
endmodule

bind scan_mode_decoder scan_mode_decoder_chk u_chk (
  .tck(tck), .rst_n(rst_n), .tlr(tlr), .update_ir(update_ir),
  .capture_dr(capture_dr), .shift_dr(shift_dr), .rti(rti), .tdi(tdi),
  .sel_bsr(sel_bsr), .test_mode(test_mode), .out_hiz(out_hiz),
  .toggle_en(toggle_en), .run_op_en(run_op_en), .tdo(tdo)
);

// File: tb/scan_mode_decoder_bench.sv
`timescale 1ns/1ps
module scan_mode_decoder_bench;
  logic       tck = 1'b0;
  logic       rst_n = 1'b0;
  logic       tlr = 1'b0, update_ir = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, rti = 1'b0;
  logic [7:0] ir_in = 8'h00;
  logic [1:0] op_sel = 2'd0;
  logic       tdi = 1'b0, bsr_tdo = 1'b0;
  logic       sel_bsr, test_mode, out_hiz, toggle_en, tdo;
  logic [1:0] cap_mode;
  logic [3:0] run_op_en;

  always #2 tck = ~tck;

  scan_mode_decoder u_scan_mode_decoder (
    .tck(tck), .rst_n(rst_n), .tlr(tlr), .update_ir(update_ir),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .rti(rti), .ir_in(ir_in),
    .op_sel(op_sel), .tdi(tdi), .bsr_tdo(bsr_tdo), .sel_bsr(sel_bsr),
    .test_mode(test_mode), .out_hiz(out_hiz), .cap_mode(cap_mode),
    .toggle_en(toggle_en), .run_op_en(run_op_en), .tdo(tdo)
  );

  typedef struct {
    logic [10:0] v;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0, n_bad = 0;
  logic byp_m = 1'b0;
  bit   done = 1'b0;

  always @(negedge tck) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [10:0] act;
      e   = q.pop_front();
      act = {sel_bsr, test_mode, out_hiz, cap_mode, toggle_en, run_op_en, tdo};
      n_cmp++;
      if (act !== e.v) begin
        n_bad++;
        $display("FAIL %s: got sel/tm/hiz/cap/tog/run/tdo=%b expected %b", e.tag, act, e.v);
      end
    end
  end

  task automatic step(input logic [7:0] ir, input logic upd, input logic t, input logic r,
                      input logic [1:0] op, input logic cap, input logic shf, input logic di,
                      input logic bt, input logic e_sel, input logic e_tm, input logic e_hiz,
                      input logic [1:0] e_cap, input logic e_tog, input logic [3:0] e_run,
                      input string tag);
    exp_t e;
    ir_in = ir; update_ir = upd; tlr = t; rti = r; op_sel = op;
    capture_dr = cap; shift_dr = shf; tdi = di; bsr_tdo = bt;
    @(posedge tck);
    #1;
    if (cap) byp_m = 1'b0;
    else if (shf) byp_m = di;
    e.v   = {e_sel, e_tm, e_hiz, e_cap, e_tog, e_run, (e_sel ? bt : byp_m)};
    e.tag = tag;
    q.push_back(e);
    @(posedge tck);
    #1;
  endtask

  initial begin
    #4000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge tck);
    #1 rst_n = 1'b1;
    // R11 reset state
    step(8'h00, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 2'd1, 0, 4'h0, "R11 reset");
    // R3 / R13
    step(8'h00, 1, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 2'd0, 0, 4'h0, "R3 extest");
    step(8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 2'd0, 0, 4'h0, "R13 bsr path");
    // R12 ir_in ignored without update
    step(8'h06, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 2'd0, 0, 4'h0, "R12 hold");
    // R11 tlr
    step(8'h06, 0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 2'd1, 0, 4'h0, "R11 tlr");
    step(8'h01, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 2'd0, 0, 4'h0, "R4 sample");
    step(8'h02, 1, 0, 1, 1, 0, 0, 0, 1, 0, 0, 1, 2'd1, 0, 4'h0, "R5 float");
    step(8'h03, 1, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 2'd1, 0, 4'h0, "R6 clamp");
    step(8'h04, 1, 0, 0, 2, 0, 0, 0, 1, 0, 1, 0, 2'd1, 0, 4'h0, "R7 run no rti");
    step(8'h04, 0, 0, 1, 2, 0, 0, 0, 1, 0, 1, 0, 2'd1, 0, 4'h4, "R7 run op2");
    step(8'h04, 0, 0, 1, 0, 0, 0, 0, 1, 0, 1, 0, 2'd1, 0, 4'h1, "R7 run op0");
    step(8'h04, 0, 0, 1, 3, 0, 0, 0, 1, 0, 1, 0, 2'd1, 0, 4'h8, "R7 run op3");
    step(8'h05, 1, 0, 1, 1, 0, 0, 0, 1, 1, 0, 0, 2'd1, 0, 4'h0, "R8 read");
    step(8'h06, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 2'd2, 0, 4'h0, "R9 selftest");
    step(8'h07, 1, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 2'd3, 0, 4'h0, "R10 toggle idle");
    step(8'h07, 0, 0, 1, 0, 0, 0, 0, 1, 0, 1, 0, 2'd3, 1, 4'h0, "R10 toggle rti");
    step(8'h5A, 1, 0, 1, 1, 0, 0, 0, 1, 0, 0, 0, 2'd1, 0, 4'h0, "R1 unknown");
    step(8'hFF, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 2'd1, 0, 4'h0, "R1 bypass");
    step(8'hFF, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 2'd1, 0, 4'h0, "R2 shift 1");
    step(8'hFF, 0, 0, 0, 0, 1, 0, 1, 1, 0, 0, 0, 2'd1, 0, 4'h0, "R2 capture 0");
    step(8'hFF, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 2'd1, 0, 4'h0, "R2 shift again");
    step(8'h00, 1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 2'd0, 0, 4'h0, "R13 back to bsr");
    @(negedge tck);
    @(negedge tck);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule